// File: doc/BRIEF.md
# General-Call Software Reset Detector

This block watches the byte stream seen by an I2C target's bus front end and looks for the general-call software reset sequence. The sequence has three parts. The first is a general-call write address byte (00h). The second is a single command byte of 06h. The third is a STOP. When all three arrive in that order, the block sends a one-clock reset pulse to the rest of the device, which returns its registers and bus state machine to their power-up values.

The front end reports START (including repeated START), STOP and each completed byte as single-cycle event strobes. For every byte, the detector answers with an acknowledge decision one cycle later. The front end uses that decision to drive or release SDA in the acknowledge slot. The detector acknowledges only two bytes: the general-call write address, and the 06h byte that directly follows it. All other bytes get no acknowledge request from this block. Addressed register traffic is handled elsewhere.

The sequence is cancelled by any of the following: a repeated START in place of the STOP, a command byte other than 06h, or any extra byte after the 06h. Any START returns the detector to checking an address byte.

Top module: `gc_swrst_detect`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sw_rst_o`, `ack_valid_o` and `ack_o` are 0. A reset during a partly received sequence discards it, so a following STOP produces no pulse.
- R2: A byte event sampled on a clock edge gives `ack_valid_o` = 1 for exactly the following cycle. When the byte is 00h and is the first byte after a START, `ack_o` = 1 in that cycle.
- R3: The first byte after a START is not acknowledged (`ack_o` = 0) if it is 01h (general call with the read bit, bit 0, set) or any value other than 00h.
- R4: The byte right after an acknowledged 00h is acknowledged only if it equals 06h. Any other value gets `ack_o` = 0.
- R5: Every byte after the acknowledged 06h gets `ack_o` = 0. A later STOP produces no reset pulse.
- R6: A STOP that directly follows the acknowledged 06h raises `sw_rst_o` in the cycle after the STOP is sampled, for exactly one cycle.
- R7: A START arriving after the acknowledged 06h, in place of the STOP, cancels the sequence. No pulse is produced, and no later STOP produces one.
- R8: Any START, including one after a cancelled sequence, restarts address checking, so a following 00h is acknowledged again.
- R9: A command byte other than 06h cancels the sequence, and the following STOP produces no pulse.
- R10: A byte with no START since reset or since the last STOP is not acknowledged, even if it is 00h.
- R11: A STOP outside a completed sequence produces no pulse.
- R12: `ack_o` is 1 only while `ack_valid_o` is 1. When START, STOP and byte events coincide, START takes priority over STOP, and STOP over the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_evt | input | 1 | One-cycle strobe: STOP seen |
| byte_valid | input | 1 | One-cycle strobe: a full byte has been received |
| byte_data | input | 8 | Received byte, valid with `byte_valid` |
| ack_valid_o | output | 1 | One-cycle strobe: acknowledge decision for the last byte |
| ack_o | output | 1 | 1 = request acknowledge for the last byte |
| sw_rst_o | output | 1 | One-cycle software reset pulse to the device |

## Verification
The hardest states to reach are the ones where the sequence is one step from completion and is then spoiled. Examples are a repeated START arriving in the armed state, or a second command byte arriving after the 06h. Only the exact full prefix leads into those states. The stimulus table therefore replays the complete 00h/06h prefix before each spoiling event. It then sends a STOP and checks that `sw_rst_o` stays low. Directed tests then apply reset partway through an armed sequence, and drive coinciding START and STOP strobes.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,      // outside any transfer
        ST_ADDR,      // START seen, waiting for address byte
        ST_GC_ACKED,  // general-call write acknowledged
        ST_ARMED,     // reset command acknowledged, waiting for STOP
        ST_ABORT      // sequence spoiled until next START
    } gc_state_e;

    typedef struct packed {
        logic is_gc_wr;   // byte equals the general-call write address
        logic is_cmd;     // byte equals the reset command value
    } byte_class_t;

    typedef struct packed {
        logic valid;
        logic ack;
    } ack_resp_t;

    function automatic ack_resp_t make_resp(input logic v, input logic a);
        ack_resp_t r;
        r.valid = v;
        r.ack   = v & a;
        return r;
    endfunction

endpackage

// File: rtl/gcsr_byte_class.sv
module gcsr_byte_class
    import gcsr_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [DATA_W-1:0] GC_WR   = '0,
    parameter logic [DATA_W-1:0] RST_CMD = DATA_W'(6)
) (
    input  logic [DATA_W-1:0] data_i,
    output byte_class_t       cls_o
);
    always_comb begin
        cls_o.is_gc_wr = (data_i == GC_WR);
        cls_o.is_cmd   = (data_i == RST_CMD);
    end
endmodule

// File: rtl/gcsr_seq_fsm.sv
module gcsr_seq_fsm
    import gcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        byte_i,
    input  byte_class_t cls_i,
    output ack_resp_t   resp_o,
    output logic        fire_o,
    output gc_state_e   state_o
);
    gc_state_e state_q, state_d;
    ack_resp_t resp_q, resp_d;

    always_comb begin
        state_d = state_q;
        resp_d  = make_resp(1'b0, 1'b0);
        fire_o  = 1'b0;
        if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            fire_o  = (state_q == ST_ARMED);
            state_d = ST_IDLE;
        end else if (byte_i) begin
            unique case (state_q)
                ST_ADDR: begin
                    resp_d  = make_resp(1'b1, cls_i.is_gc_wr);
                    state_d = cls_i.is_gc_wr ? ST_GC_ACKED : ST_IDLE;
                end
                ST_GC_ACKED: begin
                    resp_d  = make_resp(1'b1, cls_i.is_cmd);
                    state_d = cls_i.is_cmd ? ST_ARMED : ST_ABORT;
                end
                ST_ARMED: begin
                    resp_d  = make_resp(1'b1, 1'b0);
                    state_d = ST_ABORT;
                end
                default: begin
                    resp_d  = make_resp(1'b1, 1'b0);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            resp_q  <= make_resp(1'b0, 1'b0);
        end else begin
            state_q <= state_d;
            resp_q  <= resp_d;
        end
    end

    assign resp_o  = resp_q;
    assign state_o = state_q;

    AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        resp_q.valid |-> $past(byte_i)); // R2
    AST_CMD_ACK_FROM_GC: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED) |-> ($past(state_q) == ST_GC_ACKED || $past(state_q) == ST_ARMED)); // R4
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (state_q == ST_ADDR)); // R8
endmodule

// File: rtl/gcsr_pulse.sv
module gcsr_pulse (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic pulse_o
);
    logic q;
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= req_i;
    end
    assign pulse_o = q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        q |=> !q); // R6
endmodule

// File: rtl/gc_swrst_detect.sv
module gc_swrst_detect
    import gcsr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GC_ADDR = 0,
    parameter int RST_CMD = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    output logic              ack_valid_o,
    output logic              ack_o,
    output logic              sw_rst_o
);
    localparam logic [DATA_W-1:0] GC_WR_BYTE = DATA_W'(GC_ADDR << 1);
    localparam logic [DATA_W-1:0] CMD_BYTE   = DATA_W'(RST_CMD);

    byte_class_t cls;
    ack_resp_t   resp;
    logic        fire;
    gc_state_e   state;

    gcsr_byte_class #(.DATA_W(DATA_W), .GC_WR(GC_WR_BYTE), .RST_CMD(CMD_BYTE)) u_class (
        .data_i (byte_data),
        .cls_o  (cls)
    );

    gcsr_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_evt),
        .stop_i  (stop_evt),
        .byte_i  (byte_valid),
        .cls_i   (cls),
        .resp_o  (resp),
        .fire_o  (fire),
        .state_o (state)
    );

    gcsr_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .req_i   (fire),
        .pulse_o (sw_rst_o)
    );

    assign ack_valid_o = resp.valid;
    assign ack_o       = resp.ack;

    AST_ACK_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ack_valid_o); // R12
    AST_RST_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        sw_rst_o |-> ($past(stop_evt) && !$past(start_evt))); // R6
    AST_RST_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
        sw_rst_o |-> ($past(state) == ST_ARMED)); // R7
    AST_NO_ACK_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !start_evt && !stop_evt && state == ST_IDLE) |=> !ack_o); // R10
endmodule

// File: tb/gc_swrst_detect_tb.sv
module gc_swrst_detect_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_evt = 1'b0, stop_evt = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic ack_valid_o, ack_o, sw_rst_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gc_swrst_detect u_dut (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o), .sw_rst_o(sw_rst_o)
    );

    // vector: {ev[1:0], data[7:0], exp_av, exp_ack, exp_rst}; ev 0=START 1=STOP 2=BYTE 3=none
    localparam int NV = 29;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {2'd1, 8'h00, 3'b000},  // R11 stray STOP
        {2'd2, 8'h00, 3'b100},  // R10 byte without START
        {2'd0, 8'h00, 3'b000},
        {2'd2, 8'h00, 3'b110},  // R2
        {2'd2, 8'h06, 3'b110},  // R4
        {2'd1, 8'h00, 3'b001},  // R6
        {2'd3, 8'h00, 3'b000},  // R6 single cycle
        {2'd0, 8'h00, 3'b000},
        {2'd2, 8'h01, 3'b100},  // R3 read bit
        {2'd1, 8'h00, 3'b000},
        {2'd0, 8'h00, 3'b000},
        {2'd2, 8'h00, 3'b110},
        {2'd2, 8'h07, 3'b100},  // R4 / R9 wrong command
        {2'd1, 8'h00, 3'b000},  // R9
        {2'd0, 8'h00, 3'b000},
        {2'd2, 8'h00, 3'b110},
        {2'd2, 8'h06, 3'b110},
        {2'd2, 8'h06, 3'b100},  // R5 extra byte
        {2'd1, 8'h00, 3'b000},  // R5
        {2'd0, 8'h00, 3'b000},
        {2'd2, 8'h00, 3'b110},
        {2'd2, 8'h06, 3'b110},
        {2'd0, 8'h00, 3'b000},  // R7 repeated START
        {2'd2, 8'h00, 3'b110},  // R8
        {2'd2, 8'h06, 3'b110},
        {2'd1, 8'h00, 3'b001},  // R6
        {2'd0, 8'h00, 3'b000},
        {2'd2, 8'h42, 3'b100},  // R3 other address
        {2'd1, 8'h00, 3'b000}
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {av,ack,rst} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] ev, input logic [7:0] d, input logic [2:0] exp, input string req);
        start_evt  = (ev == 2'd0);
        stop_evt   = (ev == 2'd1);
        byte_valid = (ev == 2'd2);
        byte_data  = d;
        @(negedge clk);
        start_evt = 0; stop_evt = 0; byte_valid = 0;
        check(req, {ack_valid_o, ack_o, sw_rst_o}, exp);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 during reset", {ack_valid_o, ack_o, sw_rst_o}, 3'b000);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", {ack_valid_o, ack_o, sw_rst_o}, 3'b000);

        for (int i = 0; i < NV; i++)
            step(VEC[i][12:11], VEC[i][10:3], VEC[i][2:0], $sformatf("table R2-group step %0d", i));

        // R1: reset in armed state discards the sequence
        step(2'd0, 8'h00, 3'b000, "R1 seq");
        step(2'd2, 8'h00, 3'b110, "R1 seq");
        step(2'd2, 8'h06, 3'b110, "R1 seq");
        rst = 1; @(negedge clk); rst = 0;
        step(2'd1, 8'h00, 3'b000, "R1 STOP after reset");

        // R12: START and STOP together while armed -> START wins, no pulse
        step(2'd0, 8'h00, 3'b000, "R12 seq");
        step(2'd2, 8'h00, 3'b110, "R12 seq");
        step(2'd2, 8'h06, 3'b110, "R12 seq");
        start_evt = 1; stop_evt = 1;
        @(negedge clk);
        start_evt = 0; stop_evt = 0;
        check("R12 start over stop", {ack_valid_o, ack_o, sw_rst_o}, 3'b000);
        step(2'd2, 8'h00, 3'b110, "R12 back to address check");

        // R12: STOP and byte together while armed -> STOP wins, pulse, no ack
        step(2'd2, 8'h06, 3'b110, "R12 seq");
        stop_evt = 1; byte_valid = 1; byte_data = 8'h06;
        @(negedge clk);
        stop_evt = 0; byte_valid = 0;
        check("R12 stop over byte", {ack_valid_o, ack_o, sw_rst_o}, 3'b001);
        @(negedge clk);
        check("R6 pulse ends", {ack_valid_o, ack_o, sw_rst_o}, 3'b000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule